// File: doc/BRIEF.md
# Slope-Road Coincidence Finder

This block takes one bunch crossing's worth of strip hits from eight detector planes and searches them for track candidates. Each plane presents a fixed number of hit lanes per crossing, each lane carrying a valid flag and a strip address. A per-plane lookup table turns every address into a slope value. The top bits of the slope select a slope road.

The block then counts, per road, how many distinct planes have at least one hit in that road. A road becomes a candidate when this count reaches a programmable plane threshold. For every candidate, the block emits the road number, the crossing identifier, a mask of the contributing planes, the plane count, and one strip address per plane. The output is ready for a downstream slope fitter.

The eight planes follow a fixed kind pattern: two horizontal, then alternating stereo planes of the two tilts, then two horizontal. The lookup applies a kind-specific slope correction. The translated hits are held in a decode stage as tuples of slope, strip address and crossing identifier. Candidates leave one per clock. Crossings must arrive at least one road-count of clocks apart (eight clocks at the default sizes, one crossing period of the fast clock).

Top module: `slope_road_finder`

## Requirements
- R1: Slope lookup: slope = (address + d) mod 2^ADDR_W, where lane l belongs to plane l / HITS. The offset d is 0 for planes 0, 1, 6 and 7. It is +SHIFT for planes 2 and 4, and -SHIFT for planes 3 and 5. Defaults: ADDR_W = 6, SHIFT = 2.
- R2: The road of a hit is the slope shifted right by ADDR_W - ROAD_W, which gives the top three slope bits at the defaults (8 roads).
- R3: A plane adds at most one to a road's count, however many of its hits fall in that road.
- R4: A road is a candidate when its plane count is at least the effective threshold. The effective threshold is plane_thr, except that a plane_thr of 0 acts as 1. plane_thr is taken in the second clock after the crossing is sampled.
- R5: For each plane in a candidate, the forwarded address is the lowest strip address that plane has in the road. A plane with no hit in the road has a 0 mask bit and an all-zero address field. Plane p's field is cand_addr[p*ADDR_W +: ADDR_W].
- R6: Candidates of one crossing are emitted one per clock, on consecutive clocks, in ascending road order, with at most one output per road.
- R7: A crossing sampled at clock edge E yields its k-th candidate (k from 0) in the registered output after edge E+2+k. The output carries that crossing's xing_bcid and plane count.
- R8: Lanes with hit_vld low, and all lanes of a clock with xing_valid low, contribute nothing.
- R9: While rst_n is low and after its release, cand_valid stays low until a crossing yields a candidate.
- R10: A crossing with no road meeting the threshold produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_valid | input | 1 | Strobe: hit lanes hold one crossing this clock |
| xing_bcid | input | BC_W | Crossing identifier |
| hit_vld | input | PLANES*HITS | Per-lane hit valid, lane l = plane*HITS + slot |
| hit_addr | input | PLANES*HITS*ADDR_W | Per-lane strip address |
| plane_thr | input | CNT_W | Required number of distinct planes |
| cand_valid | output | 1 | Candidate present |
| cand_road | output | ROAD_W | Candidate road number |
| cand_bcid | output | BC_W | Identifier of the crossing the candidate came from |
| cand_planes | output | PLANES | Planes with a hit in the road |
| cand_count | output | CNT_W | Number of contributing planes |
| cand_addr | output | PLANES*ADDR_W | Lowest address per plane in the road |

## Verification
The main function is tried with several hit patterns:
- A straight track through all planes shows whether the stereo offsets keep it in one road.
- A track sitting on a road edge splits, because the stereo corrections push some planes across; this separates the offset sign from the road slicing.
- Repeated hits in one plane, with a threshold equal to the true plane count, expose any count by hits instead of by planes. The same pattern also checks which address is forwarded.
- Roads entered out of order, full eight-road crossings sent back to back, address wrap-around at both ends, a zero threshold, gated lanes, and a run of random crossings complete the set. All are compared every clock against a behavioural model.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    PK_HORIZ  = 2'd0,
    PK_TILT_P = 2'd1,
    PK_TILT_N = 2'd2
  } plane_kind_e;

  // Fixed plane pattern: horiz, horiz, +tilt, -tilt, +tilt, -tilt, horiz, horiz
  function automatic plane_kind_e kind_of(input int plane);
    case (plane % 8)
      2, 4:    return PK_TILT_P;
      3, 5:    return PK_TILT_N;
      default: return PK_HORIZ;
    endcase
  endfunction

  // Address-to-slope translation used to fill the per-plane tables
  function automatic int slope_lut(input int addr, input int plane,
                                   input int shift, input int addr_w);
    int span;
    int delta;
    span  = 1 << addr_w;
    case (kind_of(plane))
      PK_TILT_P: delta = shift;
      PK_TILT_N: delta = span - shift;
      default:   delta = 0;
    endcase
    return (addr + delta) % span;
  endfunction

endpackage

// File: rtl/srf_decode.sv
module srf_decode #(
  parameter int PLANES = 8,
  parameter int HITS   = 8,
  parameter int ADDR_W = 6,
  parameter int BC_W   = 12,
  parameter int SHIFT  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [BC_W-1:0]               in_bc,
  input  logic [PLANES*HITS-1:0]        in_vld,
  input  logic [PLANES*HITS*ADDR_W-1:0] in_addr,
  output logic                          s1_valid,
  output logic [BC_W-1:0]               s1_bc,
  output logic [PLANES*HITS-1:0]        s1_vld,
  output logic [PLANES*HITS*ADDR_W-1:0] s1_addr,
  output logic [PLANES*HITS*ADDR_W-1:0] s1_slope
);
  localparam int LANES = PLANES * HITS;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] slope_d [LANES];

  for (genvar gp = 0; gp < PLANES; gp++) begin : g_plane
    logic [ADDR_W-1:0] rom [DEPTH];
    always_comb begin
      for (int a = 0; a < DEPTH; a++)
        rom[a] = ADDR_W'(srf_pkg::slope_lut(a, gp, SHIFT, ADDR_W));
    end
    for (genvar gh = 0; gh < HITS; gh++) begin : g_hit
      assign slope_d[gp*HITS+gh] = rom[in_addr[(gp*HITS+gh)*ADDR_W +: ADDR_W]];
    end
  end

  // Buffered tuple: slope, strip address, crossing id
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_vld   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_vld   <= in_valid ? in_vld : '0;
    end
    s1_bc   <= in_bc;
    s1_addr <= in_addr;
    for (int l = 0; l < LANES; l++)
      s1_slope[l*ADDR_W +: ADDR_W] <= slope_d[l];
  end

  // R8: a clock without a crossing leaves no live lane behind
  p_gate_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |-> (s1_vld == '0));

endmodule

// File: rtl/srf_road_bin.sv
module srf_road_bin #(
  parameter int PLANES = 8,
  parameter int HITS   = 8,
  parameter int ADDR_W = 6,
  parameter int ROAD_W = 3,
  parameter int BC_W   = 12,
  parameter int CNT_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  s1_valid,
  input  logic [BC_W-1:0]                       s1_bc,
  input  logic [PLANES*HITS-1:0]                s1_vld,
  input  logic [PLANES*HITS*ADDR_W-1:0]         s1_addr,
  input  logic [PLANES*HITS*ADDR_W-1:0]         s1_slope,
  input  logic [CNT_W-1:0]                      thr,
  output logic                                  s2_valid,
  output logic [BC_W-1:0]                       s2_bc,
  output logic [(1<<ROAD_W)-1:0]                s2_cand,
  output logic [(1<<ROAD_W)*PLANES-1:0]         s2_pmask,
  output logic [(1<<ROAD_W)*PLANES*ADDR_W-1:0]  s2_addr,
  output logic [(1<<ROAD_W)*CNT_W-1:0]          s2_cnt
);
  localparam int ROADS = 1 << ROAD_W;
  localparam int RLSB  = ADDR_W - ROAD_W;

  logic [PLANES-1:0] pm_d  [ROADS];
  logic [ADDR_W-1:0] ad_d  [ROADS][PLANES];
  logic [CNT_W-1:0]  cnt_d [ROADS];
  logic [ROADS-1:0]  cand_d;
  logic [CNT_W-1:0]  thr_eff;
  logic [CNT_W-1:0]  thr_q;

  assign thr_eff = (thr == '0) ? CNT_W'(1) : thr;

  always_comb begin
    for (int r = 0; r < ROADS; r++) begin
      cnt_d[r] = '0;
      for (int p = 0; p < PLANES; p++) begin
        logic              hit;
        logic [ADDR_W-1:0] best;
        hit  = 1'b0;
        best = '1;
        for (int h = 0; h < HITS; h++) begin
          int l;
          l = p*HITS + h;
          if (s1_vld[l] &&
              (s1_slope[l*ADDR_W + RLSB +: ROAD_W] == ROAD_W'(r))) begin
            if (!hit || (s1_addr[l*ADDR_W +: ADDR_W] < best))
              best = s1_addr[l*ADDR_W +: ADDR_W];
            hit = 1'b1;
          end
        end
        pm_d[r][p] = hit;
        ad_d[r][p] = hit ? best : '0;
        cnt_d[r]   = cnt_d[r] + CNT_W'(hit);
      end
      cand_d[r] = s1_valid && (cnt_d[r] >= thr_eff);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_cand  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_cand  <= cand_d;
    end
    s2_bc <= s1_bc;
    thr_q <= thr_eff;
    for (int r = 0; r < ROADS; r++) begin
      s2_pmask[r*PLANES +: PLANES] <= pm_d[r];
      s2_cnt[r*CNT_W +: CNT_W]     <= cnt_d[r];
      for (int p = 0; p < PLANES; p++)
        s2_addr[(r*PLANES+p)*ADDR_W +: ADDR_W] <= ad_d[r][p];
    end
  end

  for (genvar gr = 0; gr < ROADS; gr++) begin : g_chk
    // R4: a flagged road holds enough distinct planes
    p_thr_met_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s2_cand[gr] |-> ($countones(s2_pmask[gr*PLANES +: PLANES]) >= int'(thr_q)));
    // R3: the count is the number of planes, not of hits
    p_count_planes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s2_cand[gr] |-> (int'(s2_cnt[gr*CNT_W +: CNT_W]) ==
                       $countones(s2_pmask[gr*PLANES +: PLANES])));
  end

endmodule

// File: rtl/srf_emit.sv
module srf_emit #(
  parameter int PLANES = 8,
  parameter int ADDR_W = 6,
  parameter int ROAD_W = 3,
  parameter int BC_W   = 12,
  parameter int CNT_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  s2_valid,
  input  logic [BC_W-1:0]                       s2_bc,
  input  logic [(1<<ROAD_W)-1:0]                s2_cand,
  input  logic [(1<<ROAD_W)*PLANES-1:0]         s2_pmask,
  input  logic [(1<<ROAD_W)*PLANES*ADDR_W-1:0]  s2_addr,
  input  logic [(1<<ROAD_W)*CNT_W-1:0]          s2_cnt,
  output logic                                  cand_valid,
  output logic [ROAD_W-1:0]                     cand_road,
  output logic [BC_W-1:0]                       cand_bcid,
  output logic [PLANES-1:0]                     cand_planes,
  output logic [CNT_W-1:0]                      cand_count,
  output logic [PLANES*ADDR_W-1:0]              cand_addr
);
  localparam int ROADS = 1 << ROAD_W;
  localparam int ROW_A = PLANES * ADDR_W;

  logic [ROADS-1:0]        pend;
  logic [ROADS*PLANES-1:0] snap_pm;
  logic [ROADS*ROW_A-1:0]  snap_ad;
  logic [ROADS*CNT_W-1:0]  snap_cnt;
  logic [BC_W-1:0]         snap_bc;
  logic                    out_first;

  // Named events for the checks
  logic                    load;
  logic [ROADS-1:0]        src;
  logic                    any;
  logic [ROAD_W-1:0]       sel;
  logic [ROADS*PLANES-1:0] cur_pm;
  logic [ROADS*ROW_A-1:0]  cur_ad;
  logic [ROADS*CNT_W-1:0]  cur_cnt;

  assign load    = s2_valid;
  assign src     = load ? s2_cand  : pend;
  assign cur_pm  = load ? s2_pmask : snap_pm;
  assign cur_ad  = load ? s2_addr  : snap_ad;
  assign cur_cnt = load ? s2_cnt   : snap_cnt;
  assign any     = |src;

  always_comb begin
    sel = '0;
    for (int r = ROADS-1; r >= 0; r--)
      if (src[r]) sel = ROAD_W'(r);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      cand_valid <= 1'b0;
      out_first  <= 1'b0;
    end else begin
      cand_valid <= any;
      out_first  <= load && any;
      pend       <= any ? (src & ~(ROADS'(1) << sel)) : src;
    end
    if (load) begin
      snap_pm  <= s2_pmask;
      snap_ad  <= s2_addr;
      snap_cnt <= s2_cnt;
      snap_bc  <= s2_bc;
    end
    if (any) begin
      cand_road   <= sel;
      cand_bcid   <= load ? s2_bc : snap_bc;
      cand_planes <= cur_pm[sel*PLANES +: PLANES];
      cand_addr   <= cur_ad[sel*ROW_A +: ROW_A];
      cand_count  <= cur_cnt[sel*CNT_W +: CNT_W];
    end
  end

  // R6: later outputs of one crossing climb in road number, one per clock
  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !out_first) |-> ($past(cand_valid) && (cand_road > $past(cand_road))));

  // R7: a new crossing never lands while the previous one still drains
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (pend == '0));

  for (genvar gp = 0; gp < PLANES; gp++) begin : g_zero
    // R5: an absent plane forwards no address
    p_unhit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && !cand_planes[gp]) |-> (cand_addr[gp*ADDR_W +: ADDR_W] == '0));
  end

endmodule

// File: rtl/slope_road_finder.sv
module slope_road_finder #(
  parameter int PLANES = 8,
  parameter int HITS   = 8,
  parameter int ADDR_W = 6,
  parameter int ROAD_W = 3,
  parameter int BC_W   = 12,
  parameter int SHIFT  = 2,
  parameter int CNT_W  = $clog2(PLANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          xing_valid,
  input  logic [BC_W-1:0]               xing_bcid,
  input  logic [PLANES*HITS-1:0]        hit_vld,
  input  logic [PLANES*HITS*ADDR_W-1:0] hit_addr,
  input  logic [CNT_W-1:0]              plane_thr,
  output logic                          cand_valid,
  output logic [ROAD_W-1:0]             cand_road,
  output logic [BC_W-1:0]               cand_bcid,
  output logic [PLANES-1:0]             cand_planes,
  output logic [CNT_W-1:0]              cand_count,
  output logic [PLANES*ADDR_W-1:0]      cand_addr
);
  localparam int LANES = PLANES * HITS;
  localparam int ROADS = 1 << ROAD_W;

  logic                          s1_valid;
  logic [BC_W-1:0]               s1_bc;
  logic [LANES-1:0]              s1_vld;
  logic [LANES*ADDR_W-1:0]       s1_addr;
  logic [LANES*ADDR_W-1:0]       s1_slope;

  logic                          s2_valid;
  logic [BC_W-1:0]               s2_bc;
  logic [ROADS-1:0]              s2_cand;
  logic [ROADS*PLANES-1:0]       s2_pmask;
  logic [ROADS*PLANES*ADDR_W-1:0] s2_addr;
  logic [ROADS*CNT_W-1:0]        s2_cnt;

  srf_decode #(
    .PLANES(PLANES), .HITS(HITS), .ADDR_W(ADDR_W), .BC_W(BC_W), .SHIFT(SHIFT)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .in_valid(xing_valid), .in_bc(xing_bcid), .in_vld(hit_vld), .in_addr(hit_addr),
    .s1_valid(s1_valid), .s1_bc(s1_bc), .s1_vld(s1_vld),
    .s1_addr(s1_addr), .s1_slope(s1_slope)
  );

  srf_road_bin #(
    .PLANES(PLANES), .HITS(HITS), .ADDR_W(ADDR_W), .ROAD_W(ROAD_W),
    .BC_W(BC_W), .CNT_W(CNT_W)
  ) u_bin (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_bc(s1_bc), .s1_vld(s1_vld),
    .s1_addr(s1_addr), .s1_slope(s1_slope), .thr(plane_thr),
    .s2_valid(s2_valid), .s2_bc(s2_bc), .s2_cand(s2_cand),
    .s2_pmask(s2_pmask), .s2_addr(s2_addr), .s2_cnt(s2_cnt)
  );

  srf_emit #(
    .PLANES(PLANES), .ADDR_W(ADDR_W), .ROAD_W(ROAD_W), .BC_W(BC_W), .CNT_W(CNT_W)
  ) u_emit (
    .clk(clk), .rst_n(rst_n),
    .s2_valid(s2_valid), .s2_bc(s2_bc), .s2_cand(s2_cand),
    .s2_pmask(s2_pmask), .s2_addr(s2_addr), .s2_cnt(s2_cnt),
    .cand_valid(cand_valid), .cand_road(cand_road), .cand_bcid(cand_bcid),
    .cand_planes(cand_planes), .cand_count(cand_count), .cand_addr(cand_addr)
  );

  // R9: nothing leaves the block in the clock after reset
  p_quiet_after_reset_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> !cand_valid);

endmodule

// File: tb/sim_slope_road_finder.sv
module sim_slope_road_finder;
  localparam int PLANES = 8;
  localparam int HITS   = 8;
  localparam int ADDR_W = 6;
  localparam int ROAD_W = 3;
  localparam int BC_W   = 12;
  localparam int CNT_W  = 4;
  localparam int LANES  = PLANES * HITS;
  localparam int ROADS  = 1 << ROAD_W;
  localparam int SPAN   = 1 << ADDR_W;
  localparam int LIMIT  = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xing_valid = 1'b0;
  logic [BC_W-1:0] xing_bcid = '0;
  logic [LANES-1:0] hit_vld = '0;
  logic [LANES*ADDR_W-1:0] hit_addr = '0;
  logic [CNT_W-1:0] plane_thr = '0;
  logic cand_valid;
  logic [ROAD_W-1:0] cand_road;
  logic [BC_W-1:0] cand_bcid;
  logic [PLANES-1:0] cand_planes;
  logic [CNT_W-1:0] cand_count;
  logic [PLANES*ADDR_W-1:0] cand_addr;

  slope_road_finder u0 (
    .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid), .xing_bcid(xing_bcid),
    .hit_vld(hit_vld), .hit_addr(hit_addr), .plane_thr(plane_thr),
    .cand_valid(cand_valid), .cand_road(cand_road), .cand_bcid(cand_bcid),
    .cand_planes(cand_planes), .cand_count(cand_count), .cand_addr(cand_addr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  string cur_req = "R9";

  int a_addr [PLANES][HITS];
  bit a_vld  [PLANES][HITS];

  int q_due[$];
  int q_road[$];
  int q_bc[$];
  int q_cnt[$];
  logic [PLANES-1:0] q_mask[$];
  logic [PLANES*ADDR_W-1:0] q_addr[$];

  task automatic chk(input bit ok, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
               cur_req, what, act, exp, cyc);
    end
  endtask

  function automatic int offset_of(input int p);
    if (p == 2 || p == 4) return 2;
    if (p == 3 || p == 5) return SPAN - 2;
    return 0;
  endfunction

  task automatic clear_hits();
    for (int p = 0; p < PLANES; p++)
      for (int h = 0; h < HITS; h++) begin
        a_vld[p][h]  = 1'b0;
        a_addr[p][h] = 0;
      end
  endtask

  task automatic put(input int p, input int h, input int a);
    a_vld[p][h]  = 1'b1;
    a_addr[p][h] = a;
  endtask

  // Drives one crossing at a falling edge; live=0 drives hits without strobe
  task automatic send(input int bc, input int thr, input bit live, input int gap);
    bit hp [ROADS][PLANES];
    int best [ROADS][PLANES];
    int te;
    int k;
    for (int r = 0; r < ROADS; r++)
      for (int p = 0; p < PLANES; p++) begin
        hp[r][p] = 1'b0;
        best[r][p] = 0;
      end
    for (int p = 0; p < PLANES; p++)
      for (int h = 0; h < HITS; h++)
        if (a_vld[p][h]) begin
          int s;
          int r;
          s = (a_addr[p][h] + offset_of(p)) % SPAN;
          r = s / (SPAN / ROADS);
          if (!hp[r][p] || a_addr[p][h] < best[r][p]) best[r][p] = a_addr[p][h];
          hp[r][p] = 1'b1;
        end
    te = (thr == 0) ? 1 : thr;
    k = 0;
    if (live) begin
      for (int r = 0; r < ROADS; r++) begin
        int c;
        logic [PLANES-1:0] m;
        logic [PLANES*ADDR_W-1:0] ad;
        c = 0;
        m = '0;
        ad = '0;
        for (int p = 0; p < PLANES; p++)
          if (hp[r][p]) begin
            c++;
            m[p] = 1'b1;
            ad[p*ADDR_W +: ADDR_W] = ADDR_W'(best[r][p]);
          end
        if (c >= te) begin
          q_due.push_back(cyc + 3 + k);
          q_road.push_back(r);
          q_bc.push_back(bc);
          q_cnt.push_back(c);
          q_mask.push_back(m);
          q_addr.push_back(ad);
          k++;
        end
      end
    end
    for (int p = 0; p < PLANES; p++)
      for (int h = 0; h < HITS; h++) begin
        hit_vld[p*HITS+h] = a_vld[p][h];
        hit_addr[(p*HITS+h)*ADDR_W +: ADDR_W] = ADDR_W'(a_addr[p][h]);
      end
    xing_valid = live;
    xing_bcid  = BC_W'(bc);
    plane_thr  = CNT_W'(thr);
    @(negedge clk);
    xing_valid = 1'b0;
    hit_vld    = '0;
    for (int i = 1; i < gap; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Every-clock comparison with the model queue
  always @(negedge clk) begin
    if (running) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(cand_valid === 1'b1, "valid", cand_valid, 1);
        chk(cand_road == ROAD_W'(q_road[0]), "road", cand_road, q_road[0]);
        chk(cand_bcid == BC_W'(q_bc[0]), "bcid", cand_bcid, q_bc[0]);
        chk(cand_count == CNT_W'(q_cnt[0]), "count", cand_count, q_cnt[0]);
        chk(cand_planes == q_mask[0], "planes", cand_planes, q_mask[0]);
        chk(cand_addr == q_addr[0], "addr", cand_addr, q_addr[0]);
        void'(q_due.pop_front());
        void'(q_road.pop_front());
        void'(q_bc.pop_front());
        void'(q_cnt.pop_front());
        void'(q_mask.pop_front());
        void'(q_addr.pop_front());
      end else begin
        chk(cand_valid === 1'b0, "idle valid", cand_valid, 0);
      end
    end
  end

  initial begin
    clear_hits();
    // R9: quiet in reset
    repeat (3) @(negedge clk);
    chk(cand_valid === 1'b0, "reset valid", cand_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cand_valid === 1'b0, "post-reset valid", cand_valid, 0);
    running = 1'b1;

    // R1 R2: straight track through every plane stays in one road
    cur_req = "R1 R2";
    clear_hits();
    for (int p = 0; p < PLANES; p++) put(p, 0, 20);
    send(1, 8, 1'b1, 10);

    // R1 R4: road-edge track splits (stereo offsets); thr 6 met, thr 7 not
    cur_req = "R1 R4";
    clear_hits();
    for (int p = 0; p < PLANES; p++) put(p, 3, 24);
    send(2, 6, 1'b1, 10);
    cur_req = "R4 R10";
    send(3, 7, 1'b1, 10);

    // R3: three hits from one plane count once
    cur_req = "R3";
    clear_hits();
    put(0, 0, 30); put(0, 1, 28); put(0, 2, 29); put(1, 5, 31);
    send(4, 3, 1'b1, 10);
    // R5: lowest address forwarded, absent planes zero
    cur_req = "R3 R5";
    put(6, 7, 26);
    send(5, 3, 1'b1, 10);

    // R6: roads entered out of order leave ascending
    cur_req = "R6";
    clear_hits();
    for (int p = 0; p < 2; p++) begin
      put(p, 0, 50); put(p, 1, 10); put(p, 2, 33);
    end
    send(6, 2, 1'b1, 10);

    // R8: masked lanes and an unstrobed clock contribute nothing
    cur_req = "R8";
    clear_hits();
    for (int p = 0; p < PLANES; p++) put(p, 0, 40);
    for (int p = 0; p < PLANES; p++) a_vld[p][0] = 1'b0;
    send(7, 1, 1'b1, 10);
    for (int p = 0; p < PLANES; p++) put(p, 0, 40);
    send(8, 1, 1'b0, 10);

    // R1 wrap at both ends of the address range
    cur_req = "R1 R2";
    clear_hits();
    put(2, 0, 63); put(0, 0, 1); put(3, 0, 0); put(7, 0, 62);
    send(9, 2, 1'b1, 10);

    // R4: zero threshold acts as one
    cur_req = "R4";
    clear_hits();
    put(5, 4, 40);
    send(10, 0, 1'b1, 10);

    // R7: full eight-road crossings back to back at minimum spacing
    cur_req = "R7";
    clear_hits();
    for (int h = 0; h < HITS; h++)
      for (int p = 0; p < PLANES; p++)
        put(p, h, h*8 + 4 - offset_of(p) + ((offset_of(p) > 2) ? SPAN : 0));
    send(11, 8, 1'b1, 8);
    send(12, 8, 1'b1, 8);
    send(13, 7, 1'b1, 10);

    // R3 R4 R5 R6: random crossings
    cur_req = "R3 R4 R5 R6";
    for (int i = 0; i < 40; i++) begin
      clear_hits();
      for (int p = 0; p < PLANES; p++)
        for (int h = 0; h < HITS; h++)
          if (($urandom % 3) == 0) put(p, h, int'($urandom % SPAN));
      send(100 + i, 2 + int'($urandom % 3), 1'b1, 9 + int'($urandom % 4));
    end

    repeat (20) @(negedge clk);
    cur_req = "R7";
    chk(q_due.size() == 0, "pending expected", q_due.size(), 0);
    running = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule